// File: doc/BRIEF.md
# Random Word Generator with Register Interface

This block is a small memory-mapped peripheral that produces 32-bit pseudo-random words from a seeded linear feedback shift register. It sits on a simple synchronous register bus and has four registers: control, status, entropy (write-only) and output (read-only). Once software sets the run bit, the generator steps its shift register for a fixed number of cycles. It then places the result in a one-word output buffer and raises the buffer's fill level. Reading the output takes the word and empties the buffer, and a new word is then produced.

Reading an empty buffer is an underflow. It is reported in three ways, each cleared by a different event. A per-read flag tracks whether the last output read failed. A second flag clears when the status register is read. A third flag clears only on an explicit command, and it drives a maskable error interrupt. With high assurance enabled, an underflow also sets a security-violation flag that only reset removes. A control bit or an external doze input puts the block to sleep, which freezes generation. Software may write the entropy register at any time, and the value is folded into the generator state.

The generator is a three-state machine. `GEN_IDLE` waits with an empty buffer. It moves to `GEN_SPIN` when run is set and the block is awake. `GEN_SPIN` steps the register once per awake cycle and moves to `GEN_FULL` after the last step, loading the word. `GEN_FULL` holds the word and returns to `GEN_IDLE` when the output is read.

Top module: `rng_regif`

## Requirements
- R1: After reset, control reads 0, status reads 0x00010000, output holds 0 and `err_irq` is 0.
- R2: Control bits are run [0], high assurance [1], interrupt mask [2], clear-interrupt [3] and sleep [4]. Run and high assurance are sticky: a write can set them, and only reset clears them. Mask and sleep take the written value. Bit 3 always reads 0.
- R3: Status bits [23:16] read the fixed size 1, and bits [15:8] read the fill level (0 or 1). When run is set, the block is awake and the level is 0, the condition holding after clock edge E, the level reads 1 after edge E+GEN_CYCLES+1.
- R4: The generator state resets to the seed 0x00000001. Each awake cycle in `GEN_SPIN` it becomes {s[30:0], ^(s & 0x80200003)}. Every entropy-register write XORs the write data into the state, after any step in that cycle. A result of 0 is replaced by the seed. The loaded word is the state after the final step, before that cycle's entropy XOR.
- R5: Reading the output at level 1 returns the stored word, then clears both the word and the level to 0.
- R6: Reading the output at level 0 returns 0 and sets status bits [1] (last read failed), [2] (underflow since status read) and [3] (error-interrupt).
- R7: Reading status clears bits [1] and [2] after the read returns them. A successful output read clears bit [1].
- R8: Status bit [3] stays set until a control write with bit 3 set, or reset.
- R9: An underflow while high assurance is set also sets status bit [0], which only reset clears.
- R10: `err_irq` is 1 exactly while status bit [3] is set and the interrupt mask is 0.
- R11: The block sleeps while control bit 4 or `doze_in` is 1, and status bit [4] shows this. While sleeping, the generator neither starts nor steps, and a run already in progress pauses and resumes where it stopped.
- R12: Registers sit at byte offsets 0x0 control, 0x4 status, 0x8 entropy and 0xC output. The entropy register reads 0. An access whose offset bits [1:0] are nonzero selects no register: it reads 0, writes have no effect, and an output read at such an offset is not an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational for the current access |
| doze_in | input | 1 | External sleep request |
| err_irq | output | 1 | Error interrupt request |

## Verification
Read data returns in the access cycle and reflects the state before that cycle's edge. Every side effect of a read or write is visible to the next access. The sleep bit follows `doze_in` without delay. A new word appears GEN_CYCLES+1 cycles after the start condition, so the bench reads status at exactly GEN_CYCLES+1 accesses after the run write and expects level 0, then reads again one access later and expects level 1. All inputs are driven on the falling edge and sampled 1 ns later. The reference model advances on the rising edge, so every read and every `err_irq` sample is compared against the state that follows the previous edge.

// File: rtl/rng_regif_pkg.sv
package rng_regif_pkg;

    typedef enum logic [1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_ENT  = 2'd2,
        REG_OUT  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        GEN_IDLE = 2'd0,
        GEN_SPIN = 2'd1,
        GEN_FULL = 2'd2
    } gen_state_e;

    localparam int CB_RUN  = 0;
    localparam int CB_HA   = 1;
    localparam int CB_MASK = 2;
    localparam int CB_CLR  = 3;
    localparam int CB_SLP  = 4;

    localparam int SB_SECV = 0;
    localparam int SB_LAST = 1;
    localparam int SB_UFL  = 2;
    localparam int SB_ERR  = 3;
    localparam int SB_SLP  = 4;
    localparam int SB_LVL_LO  = 8;
    localparam int SB_SIZE_LO = 16;
    localparam int FIELD_W    = 8;

endpackage

// File: rtl/rng_gen_core.sv
module rng_gen_core
    import rng_regif_pkg::*;
#(
    parameter int          DATA_W     = 32,
    parameter int          GEN_CYCLES = 32,
    parameter logic [DATA_W-1:0] SEED = 1,
    parameter logic [DATA_W-1:0] TAPS = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic              sleep_i,
    input  logic              take_i,
    input  logic              ent_wr_i,
    input  logic [DATA_W-1:0] ent_data_i,
    output logic              level_o,
    output logic [DATA_W-1:0] word_o
);

    localparam int CNT_W = (GEN_CYCLES > 1) ? $clog2(GEN_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(GEN_CYCLES - 1);

    function automatic logic [DATA_W-1:0] step(input logic [DATA_W-1:0] s);
        return {s[DATA_W-2:0], ^(s & TAPS)};
    endfunction

    gen_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] lfsr_q, lfsr_d, lfsr_stepped;
    logic [DATA_W-1:0] word_q;
    logic              adv, load, clear;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_IDLE: if (go_i && !sleep_i)            state_d = GEN_SPIN;
            GEN_SPIN: if (!sleep_i && cnt_q == CNT_LAST) state_d = GEN_FULL;
            GEN_FULL: if (take_i)                      state_d = GEN_IDLE;
            default:                                   state_d = GEN_IDLE;
        endcase
    end

    always_comb begin
        adv     = 1'b0;
        load    = 1'b0;
        clear   = 1'b0;
        level_o = 1'b0;
        unique case (state_q)
            GEN_IDLE: ;
            GEN_SPIN: begin
                adv  = !sleep_i;
                load = !sleep_i && (cnt_q == CNT_LAST);
            end
            GEN_FULL: begin
                level_o = 1'b1;
                clear   = take_i;
            end
            default: ;
        endcase
    end

    assign lfsr_stepped = step(lfsr_q);

    always_comb begin
        lfsr_d = adv ? lfsr_stepped : lfsr_q;
        if (ent_wr_i) lfsr_d = lfsr_d ^ ent_data_i;
        if (lfsr_d == '0) lfsr_d = SEED;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            cnt_q  <= '0;
            word_q <= '0;
        end else begin
            lfsr_q <= lfsr_d;
            if (state_q != GEN_SPIN) cnt_q <= '0;
            else if (adv)            cnt_q <= cnt_q + 1'b1;
            if (load)       word_q <= lfsr_stepped;
            else if (clear) word_q <= '0;
        end
    end

    assign word_o = word_q;

endmodule

// File: rtl/rng_flag_unit.sv
module rng_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic underflow_i,
    input  logic good_read_i,
    input  logic stat_read_i,
    input  logic clr_err_i,
    input  logic ha_i,
    output logic last_bad_o,
    output logic ufl_o,
    output logic err_o,
    output logic secv_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_bad_o <= 1'b0;
            ufl_o      <= 1'b0;
            err_o      <= 1'b0;
            secv_o     <= 1'b0;
        end else begin
            if (underflow_i)                     last_bad_o <= 1'b1;
            else if (good_read_i || stat_read_i) last_bad_o <= 1'b0;

            if (underflow_i)      ufl_o <= 1'b1;
            else if (stat_read_i) ufl_o <= 1'b0;

            if (underflow_i)    err_o <= 1'b1;
            else if (clr_err_i) err_o <= 1'b0;

            if (underflow_i && ha_i) secv_o <= 1'b1;
        end
    end

endmodule

// File: rtl/rng_regif.sv
module rng_regif
    import rng_regif_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 4,
    parameter int GEN_CYCLES = 32,
    parameter logic [DATA_W-1:0] LFSR_SEED = 1,
    parameter logic [DATA_W-1:0] LFSR_TAPS = 32'h8020_0003
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              doze_in,
    output logic              err_irq
);

    reg_sel_e    idx;
    logic        aligned, acc_rd, acc_wr;
    logic        rd_out, rd_stat, wr_ctrl, wr_ent;
    logic        underflow, take;
    logic        go_q, ha_q, intm_q, slp_q, sleep;
    logic        lvl, lrs, oru, erri, secv;
    logic [DATA_W-1:0] word, stat_w, ctrl_w;

    assign idx     = reg_sel_e'(bus_addr[3:2]);
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign acc_rd  = bus_sel && !bus_wr && aligned;
    assign acc_wr  = bus_sel &&  bus_wr && aligned;
    assign rd_out  = acc_rd && (idx == REG_OUT);
    assign rd_stat = acc_rd && (idx == REG_STAT);
    assign wr_ctrl = acc_wr && (idx == REG_CTRL);
    assign wr_ent  = acc_wr && (idx == REG_ENT);
    assign underflow = rd_out && !lvl;
    assign take      = rd_out &&  lvl;
    assign sleep     = slp_q | doze_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            go_q   <= 1'b0;
            ha_q   <= 1'b0;
            intm_q <= 1'b0;
            slp_q  <= 1'b0;
        end else if (wr_ctrl) begin
            go_q   <= go_q | bus_wdata[CB_RUN];
            ha_q   <= ha_q | bus_wdata[CB_HA];
            intm_q <= bus_wdata[CB_MASK];
            slp_q  <= bus_wdata[CB_SLP];
        end
    end

    rng_gen_core #(
        .DATA_W(DATA_W), .GEN_CYCLES(GEN_CYCLES),
        .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)
    ) u_gen (
        .clk(clk), .rst_n(rst_n), .go_i(go_q), .sleep_i(sleep),
        .take_i(take), .ent_wr_i(wr_ent), .ent_data_i(bus_wdata),
        .level_o(lvl), .word_o(word)
    );

    rng_flag_unit u_flags (
        .clk(clk), .rst_n(rst_n), .underflow_i(underflow), .good_read_i(take),
        .stat_read_i(rd_stat), .clr_err_i(wr_ctrl && bus_wdata[CB_CLR]),
        .ha_i(ha_q), .last_bad_o(lrs), .ufl_o(oru), .err_o(erri), .secv_o(secv)
    );

    always_comb begin
        ctrl_w = '0;
        ctrl_w[CB_RUN]  = go_q;
        ctrl_w[CB_HA]   = ha_q;
        ctrl_w[CB_MASK] = intm_q;
        ctrl_w[CB_SLP]  = slp_q;
        stat_w = '0;
        stat_w[SB_SECV] = secv;
        stat_w[SB_LAST] = lrs;
        stat_w[SB_UFL]  = oru;
        stat_w[SB_ERR]  = erri;
        stat_w[SB_SLP]  = sleep;
        stat_w[SB_LVL_LO +: FIELD_W]  = FIELD_W'(lvl);
        stat_w[SB_SIZE_LO +: FIELD_W] = FIELD_W'(1);
    end

    always_comb begin
        bus_rdata = '0;
        if (acc_rd) begin
            unique case (idx)
                REG_CTRL: bus_rdata = ctrl_w;
                REG_STAT: bus_rdata = stat_w;
                REG_ENT:  bus_rdata = '0;
                REG_OUT:  bus_rdata = word;
                default:  bus_rdata = '0;
            endcase
        end
    end

    assign err_irq = erri && !intm_q;

endmodule

// File: rtl/rng_regif_chk.sv
module rng_regif_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              clr_bit,
    input logic              level,
    input logic              go,
    input logic              ha,
    input logic              intm,
    input logic              sleep,
    input logic              erri,
    input logic              secv,
    input logic              err_irq
);

    logic rd_out, wr_ctrl, uf;
    assign rd_out  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(12));
    assign wr_ctrl = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(0));
    assign uf      = rd_out && !level;

    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) go |=> go); // R2
    AST_HA_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ha |=> ha); // R2
    AST_LEVEL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n) level |-> go); // R3
    AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) (rd_out && level) |=> !level); // R5
    AST_UFL_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n) uf |=> erri); // R6
    AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (erri && !(wr_ctrl && clr_bit)) |=> erri); // R8
    AST_SECV_STICKY: assert property (@(posedge clk) disable iff (!rst_n) secv |=> secv); // R9
    AST_UFL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (uf && !intm) |=> err_irq); // R10
    AST_SLEEP_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (sleep && !level) |=> !level); // R11

endmodule

bind rng_regif rng_regif_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .clr_bit(bus_wdata[3]), .level(lvl), .go(go_q),
    .ha(ha_q), .intm(intm_q), .sleep(sleep), .erri(erri), .secv(secv),
    .err_irq(err_irq)
);

// File: tb/sim_rng_regif.sv
`timescale 1ns/1ps
module sim_rng_regif;

    localparam int N = 32;
    localparam logic [31:0] SEED = 32'h1;
    localparam logic [31:0] TAPS = 32'h8020_0003;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_ENT = 4'h8, A_OUT = 4'hC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_sel = 1'b0, b_wr = 1'b0, b_doze = 1'b0;
    logic [3:0]  b_addr = '0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic irq;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rng_regif #(.GEN_CYCLES(N)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_sel(b_sel), .bus_wr(b_wr),
        .bus_addr(b_addr), .bus_wdata(b_wdata), .bus_rdata(rdata),
        .doze_in(b_doze), .err_irq(irq)
    );

    // reference model
    bit m_go, m_ha, m_intm, m_slp, m_lrs, m_oru, m_erri, m_secv;
    int m_ph, m_cnt;
    logic [31:0] m_lfsr, m_word;

    function automatic logic [31:0] f_step(logic [31:0] s);
        return {s[30:0], ^(s & TAPS)};
    endfunction

    function automatic logic [31:0] f_adv(logic [31:0] s, int n);
        for (int i = 0; i < n; i++) s = f_step(s);
        return s;
    endfunction

    function automatic logic [31:0] f_exp_rd(logic [3:0] a);
        logic [31:0] v = '0;
        if (a == A_CTRL) v = {27'd0, m_slp, 1'b0, m_intm, m_ha, m_go};
        else if (a == A_STAT)
            v = {8'd0, 8'd1, 7'd0, (m_ph == 2), 3'd0, (m_slp | b_doze), m_erri, m_oru, m_lrs, m_secv};
        else if (a == A_OUT) v = m_word;
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_go = 0; m_ha = 0; m_intm = 0; m_slp = 0;
            m_lrs = 0; m_oru = 0; m_erri = 0; m_secv = 0;
            m_ph = 0; m_cnt = 0; m_lfsr = SEED; m_word = '0;
        end else begin
            automatic bit sl  = m_slp | b_doze;
            automatic bit rdo = b_sel && !b_wr && b_addr == A_OUT;
            automatic bit rds = b_sel && !b_wr && b_addr == A_STAT;
            automatic bit wrc = b_sel && b_wr && b_addr == A_CTRL;
            automatic bit wre = b_sel && b_wr && b_addr == A_ENT;
            automatic bit uf  = rdo && m_ph != 2;
            automatic bit adv = (m_ph == 1) && !sl;
            automatic logic [31:0] st = adv ? f_step(m_lfsr) : m_lfsr;
            if (uf) begin
                m_lrs = 1; m_oru = 1; m_erri = 1;
                if (m_ha) m_secv = 1;
            end else begin
                if (rdo || rds) m_lrs = 0;
                if (rds) m_oru = 0;
                if (wrc && b_wdata[3]) m_erri = 0;
            end
            case (m_ph)
                0: if (m_go && !sl) begin m_ph = 1; m_cnt = 0; end
                1: if (adv) begin
                       if (m_cnt == N - 1) begin m_ph = 2; m_word = st; end
                       else m_cnt++;
                   end
                default: if (rdo) begin m_ph = 0; m_word = '0; end
            endcase
            if (wre) st = st ^ b_wdata;
            if (st == '0) st = SEED;
            m_lfsr = st;
            if (wrc) begin
                m_go = m_go | b_wdata[0]; m_ha = m_ha | b_wdata[1];
                m_intm = b_wdata[2]; m_slp = b_wdata[4];
            end
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic op(bit sel, bit wr, logic [3:0] a, logic [31:0] wd, string tag,
                      output logic [31:0] rd);
        @(negedge clk);
        b_sel = sel; b_wr = wr; b_addr = a; b_wdata = wd;
        #1;
        rd = rdata;
        if (sel && !wr) chk(tag, rdata, f_exp_rd(a));
        chk("R10 irq", {31'd0, irq}, {31'd0, m_erri && !m_intm});
    endtask

    task automatic idle(int n);
        logic [31:0] d;
        for (int i = 0; i < n; i++) op(0, 0, 4'h0, 32'h0, "idle", d);
    endtask

    initial begin
        #600000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, w1;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        op(0, 0, A_CTRL, 0, "idle", d);
        chk("R1 irq", {31'd0, irq}, 32'h0);
        op(1, 0, A_CTRL, 0, "R1 ctrl", d); chk("R1 ctrl", d, 32'h0);
        op(1, 0, A_STAT, 0, "R1 stat", d); chk("R1 stat", d, 32'h0001_0000);
        op(1, 0, A_ENT,  0, "R12 ent", d); chk("R12 ent", d, 32'h0);
        op(1, 0, 4'h5,   0, "R12 unaligned", d); chk("R12 unaligned", d, 32'h0);
        op(1, 0, 4'hD,   0, "R12 unaligned out", d); chk("R12 unaligned out", d, 32'h0);
        op(1, 0, A_STAT, 0, "R12 no ufl", d); chk("R12 no ufl", d, 32'h0001_0000);

        // underflow
        op(1, 0, A_OUT, 0, "R6 out", d); chk("R6 out", d, 32'h0);
        op(1, 0, A_STAT, 0, "R6 stat", d); chk("R6 stat", d, 32'h0001_000E);
        chk("R10 irq on", {31'd0, irq}, 32'h1);
        op(1, 0, A_STAT, 0, "R7 stat", d); chk("R7 stat", d, 32'h0001_0008);
        op(1, 1, A_CTRL, 32'h4, "R10", d);
        op(0, 0, A_CTRL, 0, "idle", d); chk("R10 masked", {31'd0, irq}, 32'h0);
        op(1, 1, A_CTRL, 32'hC, "R8", d);
        op(1, 0, A_STAT, 0, "R8 stat", d); chk("R8 stat", d, 32'h0001_0000);
        op(1, 0, A_CTRL, 0, "R2 ctrl", d); chk("R2 ctrl", d, 32'h4);

        // generation timing and word
        op(1, 1, A_CTRL, 32'h1, "R3", d);
        idle(N);
        op(1, 0, A_STAT, 0, "R3 early", d); chk("R3 early", d, 32'h0001_0000);
        op(1, 0, A_STAT, 0, "R3 due", d);   chk("R3 due", d, 32'h0001_0100);
        op(1, 0, A_OUT, 0, "R4 word", d);   chk("R4 word", d, f_adv(SEED, N));
        w1 = d;
        op(1, 0, A_STAT, 0, "R5 empty", d); chk("R5 empty", d, 32'h0001_0000);

        // sleep
        op(1, 1, A_CTRL, 32'h11, "R11", d);
        idle(3 * N);
        op(1, 0, A_STAT, 0, "R11 slp", d); chk("R11 slp", d, 32'h0001_0010);
        op(1, 1, A_CTRL, 32'h1, "R11", d);
        b_doze = 1'b1;
        idle(2 * N);
        op(1, 0, A_STAT, 0, "R11 doze", d); chk("R11 doze", d, 32'h0001_0010);
        b_doze = 1'b0;
        idle(2 * N);
        op(1, 0, A_STAT, 0, "R11 resumed", d); chk("R11 resumed", d, 32'h0001_0100);

        // entropy then high assurance
        op(1, 1, A_ENT, 32'hDEAD_BEEF, "R4 ent", d);
        op(1, 0, A_OUT, 0, "R5 out", d);
        chk("R5 word differs", {31'd0, d != w1}, 32'h1);
        op(1, 1, A_CTRL, 32'h7, "R9", d);
        op(1, 0, A_OUT, 0, "R9 ufl", d); chk("R9 ufl", d, 32'h0);
        op(1, 0, A_STAT, 0, "R9 stat", d); chk("R9 stat", d, 32'h0001_000F);
        op(1, 1, A_CTRL, 32'h0, "R2", d);
        op(1, 0, A_CTRL, 0, "R2 sticky", d); chk("R2 sticky", d, 32'h3);
        chk("R10 unmasked", {31'd0, irq}, 32'h1);
        op(1, 0, A_STAT, 0, "R9 sticky", d); chk("R9 sticky", d, 32'h0001_0009);

        // random traffic against the model
        for (int i = 0; i < 4000; i++) begin
            automatic int k = $urandom % 10;
            if ($urandom % 24 == 0) b_doze = ~b_doze;
            case (k)
                0, 1: op(1, 0, A_OUT,  0, "R5 out rnd", d);
                2, 3: op(1, 0, A_STAT, 0, "R7 stat rnd", d);
                4:    op(1, 0, A_CTRL, 0, "R2 ctrl rnd", d);
                5:    op(1, 0, A_ENT,  0, "R12 ent rnd", d);
                6:    op(1, 1, A_CTRL, $urandom & 32'h1D & ((($urandom % 4) == 0) ? 32'h1F : 32'h0D), "R2 wr", d);
                7:    op(1, 1, A_ENT,  $urandom, "R4 ent rnd", d);
                default: idle(1 + $urandom % 20);
            endcase
        end
        b_doze = 1'b0;
        op(1, 1, A_CTRL, 32'h0, "R11", d);
        idle(N + 4);
        op(1, 0, A_STAT, 0, "R3 final stat", d);
        op(1, 0, A_OUT, 0, "R4 final word", d);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule